// File: doc/BRIEF.md
# Interlocked Two-Output Timed Sequencer

This controller sequences two drive outputs that must never be on together. Two momentary push buttons control it. A start press of any length, even one clock cycle, is captured. The controller then turns on drive A for a fixed number of time-base ticks. When that period ends, drive A turns off. Both drives stay off for a short dead gap, and then drive B turns on. Drive B stays on until the halt button is pressed.

The halt button works in every active phase. It turns off whatever is on and returns the controller to idle. In idle it waits for a new start press. Timing comes from an external one-pulse-per-millisecond tick, so the default periods are 30000 ticks (30 s) for drive A and 500 ticks (0.5 s) for the gap. The buttons are assumed to be already debounced and synchronised to the clock. A two-bit phase code reports the active phase.

Top module: `interlocked_seq`

## Requirements
- R1: A start press held for a single clock cycle in idle is remembered. drive_a rises after the second rising clock edge following the press cycle, and phase_o becomes 01.
- R2: drive_a stays on for exactly A_TICKS (default 30000) tick_ms pulses counted after entry. Cycles without tick_ms do not advance the period.
- R3: When the drive A period ends, both drives are off and phase_o is 10 for exactly GAP_TICKS (default 500) tick_ms pulses.
- R4: After the gap, drive_b turns on and phase_o is 11. Drive B stays on with no time limit while halt is low.
- R5: A halt press in any active phase (01, 10 or 11) gives phase_o = 00 with both drives off after the next rising edge.
- R6: drive_a and drive_b are never high in the same cycle, whatever the internal phase register holds.
- R7: A start press during an active phase is ignored. It neither restarts the sequence nor is remembered for later.
- R8: When start and halt are high in the same cycle, halt wins and no sequence starts. A halt in the cycle after a start press also cancels that pending start.
- R9: Every phase times from zero, because the tick count clears on every phase change. The gap therefore lasts its full length no matter how the drive A period ended.
- R10: Synchronous reset forces phase 00, both drives off, and clears a start press that is still pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_ms | input | 1 | One-cycle time-base pulse |
| btn_go | input | 1 | Start button, synchronised |
| btn_halt | input | 1 | Halt button, synchronised |
| drive_a | output | 1 | First output drive |
| drive_b | output | 1 | Second output drive |
| phase_o | output | 2 | Phase code: 00 idle, 01 A on, 10 gap, 11 B on |

## Verification
A wrong phase register shows up at once on phase_o and on the drives, in the same cycle it takes its value. The bench therefore compares all three at every sampled cycle of a run. A wrong tick count or compare limit only shows when a phase ends. It appears as a drive A period or gap that is off by some ticks, which can take up to 30000 ticks to surface. For this reason the bench measures each phase length end to end, including one run with a pause in the tick stream. A start request that fails to clear shows as an unexpected restart a few cycles after a halt.

// File: rtl/interlocked_seq_pkg.sv
package interlocked_seq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'b00,
        PH_A    = 2'b01,
        PH_GAP  = 2'b10,
        PH_B    = 2'b11
    } phase_e;

    function automatic int unsigned max_u(input int unsigned x, input int unsigned y);
        return (x > y) ? x : y;
    endfunction

endpackage

// File: rtl/seq_start_latch.sv
module seq_start_latch (
    input  logic clk,
    input  logic rst,
    input  logic go,
    input  logic halt,
    input  logic idle,
    output logic req
);
    typedef struct packed {
        logic req;
    } latch_s;

    latch_s r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (halt) begin
            r_d.req = 1'b0;
        end else if (!idle) begin
            r_d.req = 1'b0;
        end else if (go) begin
            r_d.req = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req = r_q.req;
endmodule

// File: rtl/seq_interval.sv
module seq_interval #(
    parameter int unsigned CNT_W = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             clear,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CNT_TOP = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_s;

    cnt_s c_d, c_q;

    always_comb begin
        c_d = c_q;
        if (clear) begin
            c_d.cnt = '0;
        end else if (tick && (c_q.cnt != CNT_TOP)) begin
            c_d.cnt = c_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign count = c_q.cnt;
endmodule

// File: rtl/seq_phase_fsm.sv
module seq_phase_fsm
    import interlocked_seq_pkg::*;
#(
    parameter int unsigned A_TICKS   = 30000,
    parameter int unsigned GAP_TICKS = 500,
    parameter int unsigned CNT_W     = 15
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             halt,
    input  logic             req,
    input  logic [CNT_W-1:0] count,
    output phase_e           phase,
    output logic             change
);
    localparam logic [CNT_W-1:0] A_LAST   = CNT_W'(A_TICKS - 1);
    localparam logic [CNT_W-1:0] GAP_LAST = CNT_W'(GAP_TICKS - 1);

    typedef struct packed {
        phase_e ph;
    } fsm_s;

    fsm_s f_d, f_q;
    logic a_done, gap_done;

    always_comb begin
        a_done   = tick && (count == A_LAST);
        gap_done = tick && (count == GAP_LAST);
        f_d      = f_q;
        if (halt) begin
            f_d.ph = PH_IDLE;
        end else begin
            unique case (f_q.ph)
                PH_IDLE: if (req)      f_d.ph = PH_A;
                PH_A:    if (a_done)   f_d.ph = PH_GAP;
                PH_GAP:  if (gap_done) f_d.ph = PH_B;
                PH_B:    f_d.ph = PH_B;
                default: f_d.ph = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q <= '{ph: PH_IDLE};
        end else begin
            f_q <= f_d;
        end
    end

    assign phase  = f_q.ph;
    assign change = (f_d.ph != f_q.ph);
endmodule

// File: rtl/seq_drive_lock.sv
module seq_drive_lock
    import interlocked_seq_pkg::*;
(
    input  logic [1:0] phase_bits,
    output logic       drv_a,
    output logic       drv_b
);
    logic want_a, want_b;

    always_comb begin
        want_a = (phase_bits == PH_A);
        want_b = (phase_bits == PH_B);
        drv_a  = want_a & ~want_b;
        drv_b  = want_b & ~want_a;
    end
endmodule

// File: rtl/interlocked_seq.sv
module interlocked_seq
    import interlocked_seq_pkg::*;
#(
    parameter int unsigned A_TICKS   = 30000,
    parameter int unsigned GAP_TICKS = 500
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_ms,
    input  logic       btn_go,
    input  logic       btn_halt,
    output logic       drive_a,
    output logic       drive_b,
    output logic [1:0] phase_o
);
    localparam int unsigned LONGEST = max_u(A_TICKS, GAP_TICKS);
    localparam int unsigned CNT_W   = $clog2(LONGEST + 1);

    logic             req;
    logic             change;
    logic [CNT_W-1:0] count;
    phase_e           phase;

    seq_start_latch u_latch (
        .clk  (clk),
        .rst  (rst),
        .go   (btn_go),
        .halt (btn_halt),
        .idle (phase == PH_IDLE),
        .req  (req)
    );

    seq_interval #(.CNT_W(CNT_W)) u_interval (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick_ms),
        .clear (change),
        .count (count)
    );

    seq_phase_fsm #(
        .A_TICKS   (A_TICKS),
        .GAP_TICKS (GAP_TICKS),
        .CNT_W     (CNT_W)
    ) u_fsm (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick_ms),
        .halt   (btn_halt),
        .req    (req),
        .count  (count),
        .phase  (phase),
        .change (change)
    );

    seq_drive_lock u_lock (
        .phase_bits (phase),
        .drv_a      (drive_a),
        .drv_b      (drive_b)
    );

    assign phase_o = phase;
endmodule

// File: rtl/interlocked_seq_chk.sv
module interlocked_seq_chk #(
    parameter int unsigned A_TICKS   = 30000,
    parameter int unsigned GAP_TICKS = 500
) (
    input logic       clk,
    input logic       rst,
    input logic       tick_ms,
    input logic       btn_go,
    input logic       btn_halt,
    input logic       drive_a,
    input logic       drive_b,
    input logic [1:0] phase_o
);
    int unsigned a_ticks, gap_ticks;

    always_ff @(posedge clk) begin
        if (rst || phase_o != 2'b01)      a_ticks <= 0;
        else if (tick_ms)                  a_ticks <= a_ticks + 1;
        if (rst || phase_o != 2'b10)      gap_ticks <= 0;
        else if (tick_ms)                  gap_ticks <= gap_ticks + 1;
    end

    p_go_latched_r1: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b00 && btn_go && !btn_halt) ##1 !btn_halt |=> phase_o == 2'b01);

    p_a_window_r2: assert property (@(posedge clk) disable iff (rst)
        phase_o == 2'b01 |-> a_ticks < A_TICKS);

    p_a_full_r2: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b10 && $past(phase_o) == 2'b01) |-> $past(a_ticks) == A_TICKS - 1);

    p_gap_full_r3: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b11 && $past(phase_o) == 2'b10) |-> $past(gap_ticks) == GAP_TICKS - 1);

    p_gap_dark_r3: assert property (@(posedge clk) disable iff (rst)
        phase_o == 2'b10 |-> !drive_a && !drive_b);

    p_b_holds_r4: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b11 && !btn_halt) |=> phase_o == 2'b11 && drive_b);

    p_halt_idle_r5: assert property (@(posedge clk) disable iff (rst)
        btn_halt |=> phase_o == 2'b00 && !drive_a && !drive_b);

    p_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
        !(drive_a && drive_b));

    p_go_ignored_r7: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b01 && btn_go && !btn_halt && !tick_ms) |=> phase_o == 2'b01);

    p_halt_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (phase_o == 2'b00 && btn_go && btn_halt) |=> phase_o == 2'b00);
endmodule

bind interlocked_seq interlocked_seq_chk #(
    .A_TICKS   (A_TICKS),
    .GAP_TICKS (GAP_TICKS)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .tick_ms  (tick_ms),
    .btn_go   (btn_go),
    .btn_halt (btn_halt),
    .drive_a  (drive_a),
    .drive_b  (drive_b),
    .phase_o  (phase_o)
);

// File: tb/interlocked_seq_test.sv
module interlocked_seq_test;
    localparam int CLK_PERIOD = 10;
    localparam int A_T   = 30000;
    localparam int GAP_T = 500;
    localparam int WATCHDOG = 190000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_ms = 1'b0;
    logic btn_go = 1'b0;
    logic btn_halt = 1'b0;
    logic drive_a, drive_b;
    logic [1:0] phase_o;

    int checks = 0;
    int failures = 0;
    int cycles = 0;
    bit done = 1'b0;

    interlocked_seq uut (
        .clk(clk), .rst(rst), .tick_ms(tick_ms), .btn_go(btn_go),
        .btn_halt(btn_halt), .drive_a(drive_a), .drive_b(drive_b), .phase_o(phase_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WATCHDOG && !done) begin
            failures = failures + 1;
            $display("FAIL watchdog: actual cycles=%0d expected<=%0d", cycles, WATCHDOG);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic check(input string req, input int actual, input int expected);
        checks++;
        if (actual != expected) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
        end
    endtask

    task automatic check_outs(input string req, input logic [1:0] ph, input logic a, input logic b);
        check({req, " phase"}, phase_o, ph);
        check({req, " drive_a"}, drive_a, a);
        check({req, " drive_b"}, drive_b, b);
    endtask

    task automatic pulse_go();
        btn_go = 1'b1;
        step();
        btn_go = 1'b0;
    endtask

    task automatic halt_now();
        btn_halt = 1'b1;
        step();
        btn_halt = 1'b0;
    endtask

    // Count cycles with drive_a high; checks R6 on every one
    task automatic count_a(output int n);
        int bad = 0;
        n = 0;
        while (drive_a) begin
            n++;
            if (drive_b) bad++;
            step();
        end
        check("R6 overlap during A", bad, 0);
    endtask

    task automatic test_reset_r10();
        check_outs("R10 reset state", 2'b00, 1'b0, 1'b0);
        pulse_go();
        rst = 1'b1;
        step();
        rst = 1'b0;
        step(3);
        check_outs("R10 pending start cleared", 2'b00, 1'b0, 1'b0);
    endtask

    task automatic test_full_run();
        int n;
        int gap;
        int b_bad;
        tick_ms = 1'b1;
        pulse_go();
        check("R1 no drive one edge after press", drive_a, 0);
        step();
        check_outs("R1 drive A after two edges", 2'b01, 1'b1, 1'b0);
        count_a(n);
        check("R2 drive A length", n, A_T);
        gap = 0;
        b_bad = 0;
        while (phase_o == 2'b10) begin
            gap++;
            if (drive_a || drive_b) b_bad++;
            step();
        end
        check("R3 gap length", gap, GAP_T);
        check("R3 gap drives off", b_bad, 0);
        check("R9 gap timed from zero", gap, GAP_T);
        check_outs("R4 drive B on", 2'b11, 1'b0, 1'b1);
        b_bad = 0;
        for (int i = 0; i < 2000; i++) begin
            if (i == 700) btn_go = 1'b1;
            if (i == 701) btn_go = 1'b0;
            step();
            if (!(phase_o == 2'b11 && drive_b && !drive_a)) b_bad++;
        end
        check("R4 drive B holds", b_bad, 0);
        check("R7 go during B ignored", phase_o, 2'b11);
        halt_now();
        check_outs("R5 halt from B", 2'b00, 1'b0, 1'b0);
        step(4);
        check_outs("R7 no restart after halt", 2'b00, 1'b0, 1'b0);
    endtask

    task automatic test_tick_pause();
        int n;
        int bad = 0;
        tick_ms = 1'b1;
        pulse_go();
        step();
        check("R1 entry for pause run", phase_o, 2'b01);
        tick_ms = 1'b0;
        for (int i = 0; i < 700; i++) begin
            if (i == 300) btn_go = 1'b1;
            if (i == 301) btn_go = 1'b0;
            if (!drive_a) bad++;
            step();
        end
        check("R2 no advance without tick", bad, 0);
        tick_ms = 1'b1;
        count_a(n);
        check("R2 length after pause", n, A_T);
        check("R3 gap entered", phase_o, 2'b10);
        step(50);
        halt_now();
        check_outs("R5 halt from gap", 2'b00, 1'b0, 1'b0);
        step(5);
        check_outs("R7 go during A not remembered", 2'b00, 1'b0, 1'b0);
    endtask

    task automatic test_halt_in_a();
        tick_ms = 1'b1;
        pulse_go();
        step(100);
        check("R5 in A before halt", drive_a, 1);
        halt_now();
        check_outs("R5 halt from A", 2'b00, 1'b0, 1'b0);
    endtask

    task automatic test_priority_r8();
        btn_go = 1'b1;
        btn_halt = 1'b1;
        step();
        btn_go = 1'b0;
        btn_halt = 1'b0;
        step(3);
        check_outs("R8 simultaneous go and halt", 2'b00, 1'b0, 1'b0);
        pulse_go();
        halt_now();
        step(3);
        check_outs("R8 halt cancels pending go", 2'b00, 1'b0, 1'b0);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step();
        test_reset_r10();
        test_full_run();
        test_halt_in_a();
        test_priority_r8();
        test_tick_pause();
        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule